// File: doc/BRIEF.md
# Extended Data Memory Decoder

This block sits between a processor's data-pointer transfer port and two possible targets: a 2 KB on-chip extended RAM that it contains, and an external data bus. Each transfer carries a 24-bit byte address, a read or write strobe and a write byte. A configuration input opens or closes an on-chip window over the lowest 2 KB of the 24-bit space. When the window is open, addresses below 000800H are served by the on-chip RAM and all higher addresses go to the external bus. When the window is closed, every address goes to the external bus, including the lowest 2 KB.

Internal transfers take a fixed number of cycles. External transfers hold a request, with the full address, until the bus port acknowledges. The routing decision and the address, direction and data of a transfer are captured when the strobe is accepted. A later change of the configuration input or of the address inputs therefore cannot redirect or alter a transfer that is already under way.

Top module: `xdata_steer`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `ram_en` and `ext_req` are 0, and `rdata` is 00H.
- R2: With `win_en` = 1, a strobe for an address below 000800H drives `ram_en` high for exactly one cycle, starting the cycle after the strobe edge. During that cycle `ram_addr` equals address bits [10:0] and `ram_we` equals the write flag. `ext_req` stays 0, and `done` pulses in the following cycle.
- R3: With `win_en` = 1, a strobe for any address of 000800H or above raises `ext_req` with `ext_addr` equal to the full 24-bit address, and `ram_en` stays 0.
- R4: With `win_en` = 0, every address, including 000000H–0007FFH, is sent to the external bus in the same way, and the on-chip RAM contents are left unchanged.
- R5: An internal read returns, in `rdata` during the `done` cycle, the byte most recently written to the same 11-bit offset.
- R6: An external transfer holds `ext_req`, `ext_addr`, `ext_we` and `ext_wdata` stable until `ext_ack` is sampled high. `done` pulses in the cycle after that edge, and for a read `rdata` then equals `ext_rdata` as sampled with the acknowledge.
- R7: Strobes that arrive while `busy` is 1 are ignored: they start no transfer and alter no RAM byte.
- R8: The routing decision is taken from `win_en` when the strobe is accepted. A change of `win_en` during a transfer affects only later transfers.
- R9: When `rd_stb` and `wr_stb` are both high, the transfer is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_en | input | 1 | Opens the on-chip window over the lowest 2 KB |
| addr | input | 24 | Transfer byte address |
| rd_stb | input | 1 | Read strobe, accepted when idle |
| wr_stb | input | 1 | Write strobe, accepted when idle |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte of the last completed read |
| done | output | 1 | One-cycle pulse when a transfer completes |
| busy | output | 1 | A transfer is in progress |
| ram_en | output | 1 | On-chip RAM access cycle |
| ram_we | output | 1 | On-chip RAM write enable |
| ram_addr | output | 11 | On-chip RAM byte offset |
| ext_req | output | 1 | External bus request |
| ext_we | output | 1 | External transfer is a write |
| ext_addr | output | 24 | Full external byte address |
| ext_wdata | output | 8 | External write byte |
| ext_ack | input | 1 | External bus acknowledge |
| ext_rdata | input | 8 | External read byte, valid with `ext_ack` |

## Verification
A strobe is accepted at a rising edge, and the chosen target is active in the cycle that follows. For an internal transfer, `ram_en` is high one cycle after the strobe edge, and `done` with the read byte follows one cycle after that. For an external transfer, `ext_req` rises one cycle after the strobe edge and stays high until the acknowledge edge; `done` and the read byte follow one cycle after the acknowledge edge. The bench drives inputs and samples outputs on falling edges, steps exactly one falling edge per expected register stage, and compares each result against its own 2 KB model and its own routing rule.

// File: rtl/xdata_pkg.sv
package xdata_pkg;

    localparam int unsigned XD_ADDR_W    = 24;
    localparam int unsigned XD_DATA_W    = 8;
    localparam int unsigned XD_WIN_BYTES = 2048;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_INT  = 2'd1,
        ST_EXT  = 2'd2
    } xstate_e;

    typedef enum logic {
        ROUTE_EXT = 1'b0,
        ROUTE_RAM = 1'b1
    } route_e;

    typedef struct packed {
        route_e route;
        logic   wr;
    } acc_kind_t;

    function automatic int unsigned addr_bits(input int unsigned bytes);
        return (bytes <= 1) ? 1 : $clog2(bytes);
    endfunction

endpackage

// File: rtl/xdata_decode.sv
module xdata_decode
    import xdata_pkg::*;
#(
    parameter int unsigned ADDR_W = XD_ADDR_W,
    parameter int unsigned RAM_AW = 11
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              win_en,
    output route_e            route
);

    localparam int unsigned HI_W = (ADDR_W > RAM_AW) ? ADDR_W - RAM_AW : 1;

    generate
        if (ADDR_W > RAM_AW) begin : g_overlay
            logic [HI_W-1:0] hi_bits;
            logic            in_win;
            always_comb begin
                hi_bits = addr[ADDR_W-1:ADDR_W-HI_W];
                in_win  = (hi_bits == '0);
                route   = (win_en && in_win) ? ROUTE_RAM : ROUTE_EXT;
            end
        end else begin : g_full
            logic unused_addr;
            always_comb begin
                unused_addr = ^addr;
                route       = win_en ? ROUTE_RAM : ROUTE_EXT;
            end
        end
    endgenerate

endmodule

// File: rtl/xdata_ram.sv
module xdata_ram #(
    parameter int unsigned AW = 11,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en && we) begin
            mem[addr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (en && !we) begin
            q <= mem[addr];
        end
    end

endmodule

// File: rtl/xdata_ctrl.sv
module xdata_ctrl
    import xdata_pkg::*;
#(
    parameter int unsigned ADDR_W = XD_ADDR_W,
    parameter int unsigned DATA_W = XD_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  route_e            route,
    input  logic              ext_ack,
    input  logic [DATA_W-1:0] ext_rdata,
    input  logic [DATA_W-1:0] ram_q,
    output logic              busy,
    output logic              ram_en,
    output logic              ext_req,
    output logic              acc_we,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] acc_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);

    xstate_e           state_q;
    acc_kind_t         kind_q;
    logic [DATA_W-1:0] ext_q;
    route_e            last_src_q;
    logic              done_q;
    logic              strobe;

    always_comb begin
        strobe = rd_stb || wr_stb;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            kind_q     <= '{route: ROUTE_EXT, wr: 1'b0};
            acc_addr   <= '0;
            acc_wdata  <= '0;
            ext_q      <= '0;
            last_src_q <= ROUTE_EXT;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (strobe) begin
                        kind_q    <= '{route: route, wr: wr_stb};
                        acc_addr  <= addr;
                        acc_wdata <= wdata;
                        state_q   <= (route == ROUTE_RAM) ? ST_INT : ST_EXT;
                    end
                end
                ST_INT: begin
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                    if (!kind_q.wr) begin
                        last_src_q <= ROUTE_RAM;
                    end
                end
                ST_EXT: begin
                    if (ext_ack) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                        if (!kind_q.wr) begin
                            ext_q      <= ext_rdata;
                            last_src_q <= ROUTE_EXT;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy    = (state_q != ST_IDLE);
        ram_en  = (state_q == ST_INT);
        ext_req = (state_q == ST_EXT);
        acc_we  = kind_q.wr;
        done    = done_q;
        rdata   = (last_src_q == ROUTE_RAM) ? ram_q : ext_q;
    end

    AST_INT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ram_en |=> (!ram_en && done)); // R2

    AST_EXT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ext_req && !ext_ack) |=> (ext_req && $stable(acc_addr) && $stable(acc_wdata) && $stable(acc_we))); // R6

    AST_EXT_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        (ext_req && ext_ack) |=> (done && !busy)); // R6

    AST_DONE_ISOLATED: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7

    AST_BUSY_HOLDS_ADDR: assert property (@(posedge clk) disable iff (rst)
        (busy && strobe) |=> $stable(acc_addr)); // R7

endmodule

// File: rtl/xdata_steer.sv
module xdata_steer
    import xdata_pkg::*;
#(
    parameter int unsigned ADDR_W    = XD_ADDR_W,
    parameter int unsigned DATA_W    = XD_DATA_W,
    parameter int unsigned WIN_BYTES = XD_WIN_BYTES,
    localparam int unsigned RAM_AW   = addr_bits(WIN_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              win_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              done,
    output logic              busy,
    output logic              ram_en,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ext_req,
    output logic              ext_we,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_wdata,
    input  logic              ext_ack,
    input  logic [DATA_W-1:0] ext_rdata
);

    route_e            route;
    logic              acc_we;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] acc_wdata;
    logic [DATA_W-1:0] ram_q;

    xdata_decode #(
        .ADDR_W (ADDR_W),
        .RAM_AW (RAM_AW)
    ) u_decode (
        .addr   (addr),
        .win_en (win_en),
        .route  (route)
    );

    xdata_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .rd_stb    (rd_stb),
        .wr_stb    (wr_stb),
        .addr      (addr),
        .wdata     (wdata),
        .route     (route),
        .ext_ack   (ext_ack),
        .ext_rdata (ext_rdata),
        .ram_q     (ram_q),
        .busy      (busy),
        .ram_en    (ram_en),
        .ext_req   (ext_req),
        .acc_we    (acc_we),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .done      (done),
        .rdata     (rdata)
    );

    xdata_ram #(
        .AW (RAM_AW),
        .DW (DATA_W)
    ) u_ram (
        .clk   (clk),
        .rst   (rst),
        .en    (ram_en),
        .we    (acc_we),
        .addr  (acc_addr[RAM_AW-1:0]),
        .wdata (acc_wdata),
        .q     (ram_q)
    );

    always_comb begin
        ram_we    = ram_en && acc_we;
        ram_addr  = acc_addr[RAM_AW-1:0];
        ext_we    = acc_we;
        ext_addr  = acc_addr;
        ext_wdata = acc_wdata;
    end

    AST_RAM_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        ram_en |-> ((ext_addr >> RAM_AW) == '0)); // R3

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
        !(ram_en && ext_req)); // R4

    AST_WIN_CLOSED_EXT: assert property (@(posedge clk) disable iff (rst)
        (!busy && (rd_stb || wr_stb) && !win_en) |=> (ext_req && !ram_en)); // R4

    AST_WIN_OPEN_LOW: assert property (@(posedge clk) disable iff (rst)
        (!busy && (rd_stb || wr_stb) && win_en && ((addr >> RAM_AW) == '0)) |=> ram_en); // R2

endmodule

// File: tb/xdata_steer_tb.sv
module xdata_steer_tb;

    localparam int AW = 24;
    localparam int DW = 8;
    localparam int RW = 11;

    logic          clk = 1'b0;
    logic          rst;
    logic          win_en;
    logic [AW-1:0] addr;
    logic          rd_stb;
    logic          wr_stb;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic          done;
    logic          busy;
    logic          ram_en;
    logic          ram_we;
    logic [RW-1:0] ram_addr;
    logic          ext_req;
    logic          ext_we;
    logic [AW-1:0] ext_addr;
    logic [DW-1:0] ext_wdata;
    logic          ext_ack;
    logic [DW-1:0] ext_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    logic [DW-1:0] model [2048];

    always #2 clk = ~clk;

    xdata_steer u_dut (
        .clk       (clk),
        .rst       (rst),
        .win_en    (win_en),
        .addr      (addr),
        .rd_stb    (rd_stb),
        .wr_stb    (wr_stb),
        .wdata     (wdata),
        .rdata     (rdata),
        .done      (done),
        .busy      (busy),
        .ram_en    (ram_en),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ext_req   (ext_req),
        .ext_we    (ext_we),
        .ext_addr  (ext_addr),
        .ext_wdata (ext_wdata),
        .ext_ack   (ext_ack),
        .ext_rdata (ext_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7) + (a >> 8) + 8'h3C);
    endfunction

    task automatic launch(input logic [AW-1:0] a, input bit rd, input bit wr, input logic [DW-1:0] d);
        @(negedge clk);
        addr   = a;
        rd_stb = rd;
        wr_stb = wr;
        wdata  = d;
        @(negedge clk);
        rd_stb = 1'b0;
        wr_stb = 1'b0;
        addr   = ~a;
    endtask

    // internal transfer; expected route already known to be the on-chip RAM
    task automatic int_acc(input logic [AW-1:0] a, input bit wr, input logic [DW-1:0] d, input string req);
        launch(a, !wr, wr, d);
        chk(ram_en === 1'b1 && ext_req === 1'b0, req, {30'd0, ram_en, ext_req}, 32'h2);
        chk(ram_addr === a[RW-1:0], req, 32'(ram_addr), 32'(a[RW-1:0]));
        chk(ram_we === wr, req, 32'(ram_we), 32'(wr));
        if (wr) model[a[RW-1:0]] = d;
        @(negedge clk);
        chk(done === 1'b1 && ram_en === 1'b0 && busy === 1'b0, req, {29'd0, done, ram_en, busy}, 32'h4);
        if (!wr) chk(rdata === model[a[RW-1:0]], {req, " R5"}, 32'(rdata), 32'(model[a[RW-1:0]]));
    endtask

    // external transfer with a given number of wait cycles before the acknowledge
    task automatic ext_acc(input logic [AW-1:0] a, input bit wr, input logic [DW-1:0] d,
                           input logic [DW-1:0] rv, input int waits, input string req);
        launch(a, !wr, wr, d);
        for (int w = 0; w < waits; w++) begin
            chk(ext_req === 1'b1 && ram_en === 1'b0, req, {30'd0, ext_req, ram_en}, 32'h2);
            chk(ext_addr === a && ext_we === wr, {req, " R6"}, 32'(ext_addr), 32'(a));
            if (wr) chk(ext_wdata === d, {req, " R6"}, 32'(ext_wdata), 32'(d));
            @(negedge clk);
        end
        chk(ext_req === 1'b1 && ram_en === 1'b0, req, {30'd0, ext_req, ram_en}, 32'h2);
        chk(ext_addr === a && ext_we === wr, req, 32'(ext_addr), 32'(a));
        ext_ack   = 1'b1;
        ext_rdata = rv;
        @(negedge clk);
        ext_ack   = 1'b0;
        ext_rdata = 8'h00;
        chk(done === 1'b1 && ext_req === 1'b0 && busy === 1'b0, {req, " R6"}, {29'd0, done, ext_req, busy}, 32'h4);
        if (!wr) chk(rdata === rv, {req, " R6"}, 32'(rdata), 32'(rv));
    endtask

    task automatic routed(input logic [AW-1:0] a, input bit wr, input logic [DW-1:0] d, input int waits);
        bit to_ram;
        to_ram = win_en && (a < 24'h000800);
        if (to_ram) int_acc(a, wr, d, win_en ? "R2" : "R4");
        else        ext_acc(a, wr, d, d ^ 8'h5A, waits, win_en ? "R3" : "R4");
    endtask

    initial begin
        rst = 1'b1; win_en = 1'b0; addr = '0; rd_stb = 1'b0; wr_stb = 1'b0;
        wdata = '0; ext_ack = 1'b0; ext_rdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy === 1'b0 && done === 1'b0, "R1", {30'd0, busy, done}, 32'h0);
        chk(ram_en === 1'b0 && ext_req === 1'b0, "R1", {30'd0, ram_en, ext_req}, 32'h0);
        chk(rdata === 8'h00, "R1", 32'(rdata), 32'h0);

        // R2/R5: fill the whole window, then read it all back
        win_en = 1'b1;
        for (int a = 0; a < 2048; a++) int_acc(24'(a), 1'b1, pat(a), "R2");
        for (int a = 0; a < 2048; a++) int_acc(24'(a), 1'b0, 8'h00, "R5");

        // R3/R4: walking-one and boundary addresses, both window settings, varied waits
        for (int c = 0; c < 2; c++) begin
            win_en = (c == 1);
            for (int b = 0; b < AW; b++) begin
                routed(24'd1 << b, 1'b0, 8'(b * 11), b % 4);
                routed(24'd1 << b, 1'b1, 8'(b * 13 + c), (b + 1) % 3);
            end
            routed(24'h0007FF, 1'b0, 8'h11, 1);
            routed(24'h000800, 1'b0, 8'h22, 0);
            routed(24'h0007FF, 1'b1, 8'hC3, 2);
            routed(24'h000800, 1'b1, 8'h3C, 0);
            routed(24'hFFFFFF, 1'b0, 8'h44, 3);
            routed(24'h000000, 1'b0, 8'h66, 0);
        end

        // R4: window closed writes to low addresses left the RAM untouched
        win_en = 1'b1;
        int_acc(24'h000000, 1'b0, 8'h00, "R4");
        int_acc(24'h000400, 1'b0, 8'h00, "R4");
        int_acc(24'h0007FF, 1'b0, 8'h00, "R4");

        // R7: strobes during an external wait are ignored
        launch(24'h123456, 1'b1, 1'b0, 8'h00);
        @(negedge clk);
        addr = 24'h000010; wr_stb = 1'b1; wdata = 8'hEE;
        @(negedge clk);
        wr_stb = 1'b0;
        chk(ext_req === 1'b1 && ext_addr === 24'h123456 && ram_en === 1'b0, "R7", 32'(ext_addr), 32'h123456);
        ext_ack = 1'b1; ext_rdata = 8'h9D;
        @(negedge clk);
        ext_ack = 1'b0;
        chk(done === 1'b1 && rdata === 8'h9D, "R7", 32'(rdata), 32'h9D);
        @(negedge clk);
        chk(busy === 1'b0 && ext_req === 1'b0 && ram_en === 1'b0, "R7", {29'd0, busy, ext_req, ram_en}, 32'h0);
        int_acc(24'h000010, 1'b0, 8'h00, "R7");

        // R8: window opened during an external transfer to a low address
        win_en = 1'b0;
        launch(24'h000020, 1'b0, 1'b1, 8'h5A);
        win_en = 1'b1;
        @(negedge clk);
        chk(ext_req === 1'b1 && ram_en === 1'b0 && ext_addr === 24'h000020, "R8", 32'(ext_addr), 32'h20);
        ext_ack = 1'b1;
        @(negedge clk);
        ext_ack = 1'b0;
        chk(done === 1'b1, "R8", 32'(done), 32'h1);
        int_acc(24'h000020, 1'b0, 8'h00, "R8");
        // R8: window closed during an internal transfer still completes internally
        launch(24'h000030, 1'b0, 1'b1, 8'hB7);
        model[11'h030] = 8'hB7;
        win_en = 1'b0;
        chk(ram_en === 1'b1 && ext_req === 1'b0, "R8", {30'd0, ram_en, ext_req}, 32'h2);
        @(negedge clk);
        chk(done === 1'b1, "R8", 32'(done), 32'h1);
        routed(24'h000030, 1'b0, 8'h77, 1);
        win_en = 1'b1;
        int_acc(24'h000030, 1'b0, 8'h00, "R8");

        // R9: both strobes together perform a write
        launch(24'h000040, 1'b1, 1'b1, 8'h77);
        chk(ram_en === 1'b1 && ram_we === 1'b1, "R9", {30'd0, ram_en, ram_we}, 32'h3);
        model[11'h040] = 8'h77;
        @(negedge clk);
        int_acc(24'h000040, 1'b0, 8'h00, "R9");
        win_en = 1'b0;
        launch(24'h200000, 1'b1, 1'b1, 8'h81);
        chk(ext_req === 1'b1 && ext_we === 1'b1 && ext_wdata === 8'h81, "R9", 32'(ext_wdata), 32'h81);
        ext_ack = 1'b1;
        @(negedge clk);
        ext_ack = 1'b0;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule